// File: doc/BRIEF.md
# Smart-Card Half-Duplex UART with Parity-Error Handshake

This block is an asynchronous serial transceiver for a smart-card style link, in which the transmit and receive paths share a single open-drain wire. A character on the wire is a low start bit, eight data bits sent least significant bit first, an even parity bit and a single stop bit. The block never drives the wire high. It either pulls the wire low or releases it, and an external pull-up supplies the high level.

The parity handshake runs in both directions. When the receiver finds a bad parity bit, it holds the wire low for the whole stop-bit slot. When the block transmits, it reads the wire back in the middle of its own stop-bit slot. A low level there means the far end rejected the character, and the block sets an error flag. The host side is a set of register-style strobes and fields: a transmit-buffer write, a receive-buffer read, separate enables for each direction, an 8-bit baud setting, a clock-source select and a divide field. It also provides status flags and two interrupt request flags that stay set until they are acknowledged.

The bit period is built from a prescaled clock enable and an 8-bit reload counter. The reload counter produces sixteen sub-bit ticks per bit.

Top module: `sc_uart`

## Requirements
- R1: A transmitted character appears on the wire as a low start bit, then D0 to D7 least significant bit first, then an even parity bit (the XOR of the eight data bits), then a released stop bit.
- R2: One bit lasts 16 × (baud_m + 1) × K clock cycles. K is 1 for clk_sel = 2'b00, 8 for 2'b01, 2 × div_n for 2'b10 (or 1 when div_n = 0), and 1 for 2'b11.
- R3: After a buffer write with tx_en high, the start bit begins at the next sub-bit tick, no more than (baud_m + 1) × K + 2 cycles later. tx_buf_empty returns to 1 when the byte moves into the shift register.
- R4: line_drive_low = 1 means the wire is pulled low. The transmitter never pulls the wire low during its stop-bit slot, and after reset nothing pulls it low.
- R5: The transmitter samples the wire in the middle of its stop-bit slot and sets tx_err if the wire is low there. tx_err is cleared when the next character starts.
- R6: The receiver confirms a falling edge only if the wire is still low half a bit later. A shorter low pulse produces no character and no pull-down.
- R7: At the end of the stop-bit slot the receiver places the byte on rx_rdata and sets rx_valid. rx_valid stays set until rx_rd is pulsed.
- R8: On a parity mismatch the receiver pulls the wire low for its stop-bit slot and reports rx_perr = 1 with the character. The data byte is still delivered.
- R9: On correct parity the receiver leaves the wire released in the stop-bit slot and reports rx_perr = 0.
- R10: With tx_irq_at_end = 1, tx_irq is set when the stop bit completes. With tx_irq_at_end = 0, it is set when the byte moves from the buffer into the shift register. tx_idle is 1 whenever no character is being shifted out.
- R11: tx_irq and rx_irq stay set until tx_ack or rx_ack, respectively, is pulsed.
- R12: With tx_en = 0 a written byte waits in the buffer and the wire stays released. With rx_en = 0 an incoming character is neither stored nor answered with a pull-down.
- R13: After reset, tx_buf_empty = 1, tx_idle = 1, tx_err = 0, rx_valid = 0, tx_irq = 0, rx_irq = 0 and line_drive_low = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Allow transmission |
| rx_en | input | 1 | Allow reception |
| clk_sel | input | 2 | Clock source: 00 undivided, 01 divide by 8, 10 divide by 2·div_n, 11 undivided |
| div_n | input | DIVN_W | Divide field for clk_sel = 10 |
| baud_m | input | BAUD_W | Baud reload value m |
| tx_irq_at_end | input | 1 | 1: transmit interrupt at completion, 0: at buffer transfer |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_wdata | input | DATA_W | Byte to transmit |
| rx_rd | input | 1 | Read strobe, clears rx_valid |
| rx_rdata | output | DATA_W | Last received byte |
| tx_ack | input | 1 | Clears tx_irq |
| rx_ack | input | 1 | Clears rx_irq |
| tx_buf_empty | output | 1 | Transmit buffer free |
| tx_idle | output | 1 | Shift register empty |
| tx_err | output | 1 | Far end rejected the last character |
| rx_valid | output | 1 | Received byte waiting |
| rx_perr | output | 1 | Parity error on the last received byte |
| tx_irq | output | 1 | Transmit interrupt request flag |
| rx_irq | output | 1 | Receive interrupt request flag |
| line_in | input | 1 | Level of the shared wire |
| line_drive_low | output | 1 | 1 pulls the shared wire low |

## Verification
The bench reads every transmitted bit at the middle of its slot, using a period it computes itself for each clock-source setting. A wrong divider or reload count would drift out of alignment within a few bits and fail the check. A behavioural card pulls the wire low during the stop slot. The bench expects tx_err to follow that pull-down, which catches a transmitter that samples outside the slot or forgets to clear the flag. On the receive side the card sends characters with good and bad parity and a short low glitch. A receiver that skips the half-bit confirmation, answers good parity with a pull-down or loses the byte on a parity error shows up at the wire or at rx_rdata. Both interrupt modes, the hold-until-acknowledge behaviour and the disabled directions are also checked.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;

   typedef enum logic [1:0] {
      SEL_DIV1  = 2'b00,
      SEL_DIV8  = 2'b01,
      SEL_DIV2N = 2'b10,
      SEL_ALT1  = 2'b11
   } clk_sel_e;

   typedef enum logic {
      RX_IDLE = 1'b0,
      RX_ACT  = 1'b1
   } rx_state_e;

endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r <= {STAGES{RST_VAL}};
            end else begin
               r[0] <= d;
               for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
            end
         end
         assign q = r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sc_baud_gen.sv
module sc_baud_gen
   import sc_uart_pkg::*;
#(
   parameter int BAUD_W = 8,
   parameter int DIVN_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        clk_sel,
   input  logic [DIVN_W-1:0] div_n,
   input  logic [BAUD_W-1:0] baud_m,
   output logic              tick
);

   localparam int PRE_W = (DIVN_W + 1 > 3) ? DIVN_W + 1 : 3;

   logic [PRE_W-1:0]  pcnt;
   logic [PRE_W-1:0]  lim;
   logic              ce;
   logic [BAUD_W-1:0] bcnt;

   // prescaler terminal count for the selected source
   always_comb begin
      case (clk_sel_e'(clk_sel))
         SEL_DIV8:  lim = PRE_W'(7);
         SEL_DIV2N: lim = (div_n == '0) ? '0 : PRE_W'({div_n, 1'b0}) - PRE_W'(1);
         default:   lim = '0;
      endcase
   end

   assign ce   = (pcnt >= lim);
   assign tick = ce && (bcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
         bcnt <= '0;
      end else begin
         pcnt <= ce ? '0 : pcnt + PRE_W'(1);
         if (ce) bcnt <= (bcnt == '0) ? baud_m : bcnt - BAUD_W'(1);
      end
   end

   // R2: a nonzero reload keeps sub-bit ticks apart
   a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && baud_m != '0) |=> !tick);
   // R2: divide-by-8 enable is never on two cycles running
   a_r2_div8_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && clk_sel == SEL_DIV8) |=> (!ce || clk_sel != SEL_DIV8));

endmodule

// File: rtl/sc_tx.sv
module sc_tx #(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              tx_en,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              line_s,
   output logic              drv_low,
   output logic              buf_empty,
   output logic              sh_empty,
   output logic              err,
   output logic              load_evt,
   output logic              done_evt
);

   localparam int FRM   = DATA_W + 3;
   localparam int IDX_W = $clog2(FRM);
   localparam int CNT_W = $clog2(OVS);
   localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(FRM - 1);
   localparam logic [CNT_W-1:0] MID      = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] LAST     = CNT_W'(OVS - 1);

   logic [DATA_W-1:0] tbuf;
   logic              tfull;
   logic [FRM-1:0]    sh;
   logic              busy;
   logic [IDX_W-1:0]  idx;
   logic [CNT_W-1:0]  cnt;

   assign load_evt  = !busy && tfull && tx_en && tick;
   assign done_evt  = busy && tick && (cnt == LAST) && (idx == STOP_IDX);
   assign drv_low   = busy && !sh[0];
   assign buf_empty = !tfull;
   assign sh_empty  = !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbuf  <= '0;
         tfull <= 1'b0;
         sh    <= '1;
         busy  <= 1'b0;
         idx   <= '0;
         cnt   <= '0;
         err   <= 1'b0;
      end else begin
         if (wr) tbuf <= wdata;
         tfull <= wr ? 1'b1 : (load_evt ? 1'b0 : tfull);
         if (load_evt) begin
            sh   <= {1'b1, ^tbuf, tbuf, 1'b0};
            busy <= 1'b1;
            idx  <= '0;
            cnt  <= '0;
            err  <= 1'b0;
         end else if (busy && tick) begin
            cnt <= cnt + CNT_W'(1);
            // far end answers a bad character by holding the stop slot low
            if (cnt == MID && idx == STOP_IDX && !line_s) err <= 1'b1;
            if (cnt == LAST) begin
               cnt <= '0;
               sh  <= {1'b1, sh[FRM-1:1]};
               if (idx == STOP_IDX) busy <= 1'b0;
               else                 idx  <= idx + IDX_W'(1);
            end
         end
      end
   end

   // R3: a tick with a full buffer starts the shift register
   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && tfull && tx_en && tick && !wr) |=> (busy && !tfull));
   // R4: the stop slot is always released by the transmitter
   a_r4_stop_released: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx == STOP_IDX) |-> !drv_low);
   // R5: a new character starts with a clear error flag
   a_r5_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !err);
   // R1: slot index moves only at a slot boundary
   a_r1_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(tick && cnt == LAST)) |=> (idx == $past(idx)));

endmodule

// File: rtl/sc_rx.sv
module sc_rx
   import sc_uart_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_en,
   input  logic              line_s,
   input  logic              rd,
   output logic              drv_low,
   output logic [DATA_W-1:0] data,
   output logic              valid,
   output logic              perr,
   output logic              done_evt
);

   localparam int FRM   = DATA_W + 3;
   localparam int IDX_W = $clog2(FRM);
   localparam int CNT_W = $clog2(OVS);
   localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(FRM - 1);
   localparam logic [IDX_W-1:0] PAR_IDX  = IDX_W'(FRM - 2);
   localparam logic [CNT_W-1:0] MID      = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] LAST     = CNT_W'(OVS - 1);

   rx_state_e        st;
   logic             line_prev;
   logic [IDX_W-1:0] idx;
   logic [CNT_W-1:0] cnt;
   logic [DATA_W:0]  sh;
   logic             low_q;

   assign drv_low  = low_q;
   assign done_evt = (st == RX_ACT) && tick && (cnt == LAST) && (idx == STOP_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RX_IDLE;
         line_prev <= 1'b1;
         idx       <= '0;
         cnt       <= '0;
         sh        <= '0;
         low_q     <= 1'b0;
         data      <= '0;
         valid     <= 1'b0;
         perr      <= 1'b0;
      end else begin
         line_prev <= line_s;
         if (done_evt) valid <= 1'b1;
         else if (rd)  valid <= 1'b0;
         case (st)
            RX_IDLE: begin
               if (rx_en && line_prev && !line_s) begin
                  st  <= RX_ACT;
                  idx <= '0;
                  cnt <= '0;
               end
            end
            default: begin
               if (tick) begin
                  cnt <= cnt + CNT_W'(1);
                  if (cnt == MID) begin
                     if (idx == '0) begin
                        if (line_s) st <= RX_IDLE;   // glitch, not a start bit
                     end else if (idx != STOP_IDX) begin
                        sh <= {line_s, sh[DATA_W:1]};
                     end
                  end
                  if (cnt == LAST) begin
                     cnt <= '0;
                     if (idx == PAR_IDX) begin
                        low_q <= ^sh;                // odd count of ones: reject
                        idx   <= idx + IDX_W'(1);
                     end else if (idx == STOP_IDX) begin
                        st    <= RX_IDLE;
                        low_q <= 1'b0;
                        data  <= sh[DATA_W-1:0];
                        perr  <= low_q;
                     end else begin
                        idx <= idx + IDX_W'(1);
                     end
                  end
               end
            end
         endcase
      end
   end

   // R8: the error pull-down lives only inside the stop slot
   a_r8_low_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
      drv_low |-> (st == RX_ACT && idx == STOP_IDX));
   // R6: a start bit that is high at mid-bit is dropped
   a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_ACT && idx == '0 && tick && cnt == MID && line_s) |=> (st == RX_IDLE));
   // R7: a waiting byte stays flagged until read
   a_r7_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !rd) |=> valid);

endmodule

// File: rtl/sc_uart.sv
module sc_uart #(
   parameter int DATA_W      = 8,
   parameter int BAUD_W      = 8,
   parameter int DIVN_W      = 4,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic [1:0]        clk_sel,
   input  logic [DIVN_W-1:0] div_n,
   input  logic [BAUD_W-1:0] baud_m,
   input  logic              tx_irq_at_end,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_rdata,
   input  logic              tx_ack,
   input  logic              rx_ack,
   output logic              tx_buf_empty,
   output logic              tx_idle,
   output logic              tx_err,
   output logic              rx_valid,
   output logic              rx_perr,
   output logic              tx_irq,
   output logic              rx_irq,
   input  logic              line_in,
   output logic              line_drive_low
);

   generate
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 4");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
      if (BAUD_W < 1 || DIVN_W < 1) begin : g_bad_div
         $error("BAUD_W and DIVN_W must be positive");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic line_s, tick;
   logic tx_low, rx_low;
   logic tx_load, tx_done, rx_done;

   sc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s));

   sc_baud_gen #(.BAUD_W(BAUD_W), .DIVN_W(DIVN_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .div_n(div_n),
      .baud_m(baud_m), .tick(tick));

   sc_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .wr(tx_wr),
      .wdata(tx_wdata), .line_s(line_s), .drv_low(tx_low),
      .buf_empty(tx_buf_empty), .sh_empty(tx_idle), .err(tx_err),
      .load_evt(tx_load), .done_evt(tx_done));

   sc_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en), .line_s(line_s),
      .rd(rx_rd), .drv_low(rx_low), .data(rx_rdata), .valid(rx_valid),
      .perr(rx_perr), .done_evt(rx_done));

   // open-drain: either end may only pull the wire down
   assign line_drive_low = tx_low | rx_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_irq <= 1'b0;
         rx_irq <= 1'b0;
      end else begin
         if (tx_irq_at_end ? tx_done : tx_load) tx_irq <= 1'b1;
         else if (tx_ack)                       tx_irq <= 1'b0;
         if (rx_done)     rx_irq <= 1'b1;
         else if (rx_ack) rx_irq <= 1'b0;
      end
   end

   // R11: request flags persist until acknowledged
   a_r11_tx_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_irq && !tx_ack) |=> tx_irq);
   a_r11_rx_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_irq && !rx_ack) |=> rx_irq);
   // R10: completion-mode request arrives with the shift register empty
   a_r10_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tx_irq) && $past(tx_irq_at_end)) |-> tx_idle);

endmodule

// File: tb/sim_sc_uart.sv
`timescale 1ns/100ps
module sim_sc_uart;

   logic       clk, rst_n, tx_en, rx_en, tx_irq_at_end, tx_wr, rx_rd, tx_ack, rx_ack;
   logic       card_low;
   logic [1:0] clk_sel;
   logic [3:0] div_n;
   logic [7:0] baud_m, tx_wdata;
   logic [7:0] rx_rdata;
   logic       tx_buf_empty, tx_idle, tx_err, rx_valid, rx_perr, tx_irq, rx_irq;
   logic       line_drive_low;
   wire        line = ~(line_drive_low | card_low);   // pull-up plus two open drains

   int checks = 0;
   int failures = 0;
   int P = 16;
   int T = 1;

   sc_uart u0 (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .clk_sel(clk_sel),
      .div_n(div_n), .baud_m(baud_m), .tx_irq_at_end(tx_irq_at_end),
      .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
      .tx_ack(tx_ack), .rx_ack(rx_ack), .tx_buf_empty(tx_buf_empty),
      .tx_idle(tx_idle), .tx_err(tx_err), .rx_valid(rx_valid), .rx_perr(rx_perr),
      .tx_irq(tx_irq), .rx_irq(rx_irq), .line_in(line),
      .line_drive_low(line_drive_low));

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int bit_period(input int sel, input int n, input int m);
      int k;
      case (sel)
         1:       k = 8;
         2:       k = (n == 0) ? 1 : 2 * n;
         default: k = 1;
      endcase
      return 16 * (m + 1) * k;
   endfunction

   function automatic bit fbit(input logic [7:0] b, input int k, input bit bad);
      if (k == 0) return 1'b0;
      if (k <= 8) return b[k-1];
      if (k == 9) return (^b) ^ bad;
      return 1'b1;
   endfunction

   task automatic set_cfg(input int c);
      int s, n, m;
      case (c)
         0:       begin s = 0; n = 0; m = 3; end
         1:       begin s = 1; n = 0; m = 0; end
         2:       begin s = 2; n = 2; m = 1; end
         3:       begin s = 2; n = 0; m = 5; end
         4:       begin s = 3; n = 5; m = 0; end
         default: begin s = 0; n = 0; m = 0; end
      endcase
      clk_sel = 2'(s);
      div_n   = 4'(n);
      baud_m  = 8'(m);
      P = bit_period(s, n, m);
      T = P / 16;
      step(64);
   endtask

   // DUT transmits; bench reads the wire and may answer with an error pull-down
   task automatic dut_send(input logic [7:0] b, input bit inj, input bit wr, input bit at_end);
      int lat;
      tx_irq_at_end = at_end;
      if (wr) begin
         tx_wdata = b;
         tx_wr = 1'b1;
         step(1);
         tx_wr = 1'b0;
      end
      lat = 0;
      while (line !== 1'b0 && lat < 4000) begin
         step(1);
         lat++;
      end
      chk("R3 start within one tick", int'(lat <= T + 2), 1);
      chk("R3 buffer empty after transfer", int'(tx_buf_empty), 1);
      chk("R5 error clear at start", int'(tx_err), 0);
      chk("R10 irq at transfer per mode", int'(tx_irq), at_end ? 0 : 1);
      chk("R10 shift register busy", int'(tx_idle), 0);
      step(P / 2);
      for (int k = 0; k < 10; k++) begin
         chk($sformatf("R1 R2 bit %0d of %02h", k, b), int'(line), int'(fbit(b, k, 1'b0)));
         if (k < 9) step(P);
      end
      step(P / 2);
      card_low = inj;
      step(P / 2);
      chk("R4 tx releases stop slot", int'(line_drive_low), 0);
      chk("R5 wire in stop slot", int'(line), inj ? 0 : 1);
      step(P / 2);
      card_low = 1'b0;
      step(2);
      chk("R5 error flag", int'(tx_err), int'(inj));
      chk("R10 idle after stop", int'(tx_idle), 1);
      chk("R10 irq set", int'(tx_irq), 1);
      step(5);
      chk("R11 irq held", int'(tx_irq), 1);
      tx_ack = 1'b1;
      step(1);
      tx_ack = 1'b0;
      chk("R11 irq cleared by ack", int'(tx_irq), 0);
      step(P);
   endtask

   // card transmits; bench checks the DUT receiver
   task automatic card_send(input logic [7:0] b, input bit bad, input bit expect_rx);
      for (int k = 0; k < 10; k++) begin
         card_low = !fbit(b, k, bad);
         step(P);
      end
      card_low = 1'b0;
      step(P / 2);
      chk(bad ? "R8 error pull-down in stop" : "R9 stop released",
          int'(line_drive_low), int'(expect_rx && bad));
      step(P);
      chk("R7 R12 byte flagged", int'(rx_valid), int'(expect_rx));
      if (expect_rx) begin
         chk("R7 byte value", int'(rx_rdata), int'(b));
         chk(bad ? "R8 parity error" : "R9 parity ok", int'(rx_perr), int'(bad));
         chk("R8 pull-down released", int'(line_drive_low), 0);
         chk("R11 rx irq set", int'(rx_irq), 1);
         step(3);
         chk("R7 byte still flagged", int'(rx_valid), 1);
         rx_rd = 1'b1;
         rx_ack = 1'b1;
         step(1);
         rx_rd = 1'b0;
         rx_ack = 1'b0;
         chk("R7 read clears flag", int'(rx_valid), 0);
         chk("R11 rx irq cleared", int'(rx_irq), 0);
      end else begin
         chk("R12 no rx irq", int'(rx_irq), 0);
      end
      step(P);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int lows;
      rst_n = 1'b0; tx_en = 1'b1; rx_en = 1'b0; tx_irq_at_end = 1'b1;
      tx_wr = 1'b0; rx_rd = 1'b0; tx_ack = 1'b0; rx_ack = 1'b0; card_low = 1'b0;
      clk_sel = 2'b00; div_n = 4'd0; baud_m = 8'd0; tx_wdata = 8'h00;
      void'($urandom(32'd4242));
      step(5);
      rst_n = 1'b1;
      step(2);

      chk("R13 buffer empty", int'(tx_buf_empty), 1);
      chk("R13 idle", int'(tx_idle), 1);
      chk("R13 no error", int'(tx_err), 0);
      chk("R13 no byte", int'(rx_valid), 0);
      chk("R13 tx irq", int'(tx_irq), 0);
      chk("R13 rx irq", int'(rx_irq), 0);
      chk("R13 R4 wire released", int'(line_drive_low), 0);

      set_cfg(0);
      dut_send(8'hA5, 1'b0, 1'b1, 1'b1);
      dut_send(8'h3C, 1'b1, 1'b1, 1'b0);
      dut_send(8'h00, 1'b0, 1'b1, 1'b1);

      // R12 transmit disabled
      set_cfg(2);
      tx_en = 1'b0;
      tx_wdata = 8'hFF;
      tx_wr = 1'b1;
      step(1);
      tx_wr = 1'b0;
      lows = 0;
      for (int i = 0; i < 3 * P; i++) begin
         step(1);
         if (line === 1'b0) lows++;
      end
      chk("R12 wire quiet while disabled", lows, 0);
      chk("R12 byte held in buffer", int'(tx_buf_empty), 0);
      chk("R12 shift register idle", int'(tx_idle), 1);
      tx_en = 1'b1;
      dut_send(8'hFF, 1'b1, 1'b0, 1'b1);

      // receive side
      rx_en = 1'b1;
      set_cfg(3);
      card_send(8'h5A, 1'b0, 1'b1);
      card_send(8'h81, 1'b1, 1'b1);
      card_low = 1'b1;
      step(2);
      card_low = 1'b0;
      step(2 * P);
      chk("R6 glitch gives no byte", int'(rx_valid), 0);
      chk("R6 glitch gives no pull-down", int'(line_drive_low), 0);
      card_send(8'h7E, 1'b0, 1'b1);
      rx_en = 1'b0;
      card_send(8'hC3, 1'b1, 1'b0);

      // mixed random traffic over all clock settings
      for (int it = 0; it < 24; it++) begin
         logic [7:0] rb;
         bit         r1, r2;
         rb = 8'($urandom);
         r1 = 1'($urandom % 2);
         r2 = 1'($urandom % 2);
         set_cfg(int'($urandom % 6));
         if (($urandom % 2) == 0) begin
            rx_en = 1'b0;
            dut_send(rb, r1, 1'b1, r2);
         end else begin
            rx_en = 1'b1;
            card_send(rb, r1, 1'b1);
         end
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule